// File: doc/BRIEF.md
# Serial Receive Framer with Parity and CRC Stripping

The framer sits behind a bit-recovery stage. That stage delivers one data bit per `bit_valid` strobe, plus single-cycle start and end markers that bound each frame. The framer packs the bits into bytes and checks and removes each byte's parity bit. It runs a CRC over the frame and drops the two trailing check bytes. Only payload bytes go out, on a valid/ready byte port. The markers are used internally and never show up as data.

At the start of a frame the block pulses a start indication. At the end it pulses a done strobe with three separate error flags: parity, CRC and framing. Payload leaves through a small output queue. A downstream consumer can stall briefly without losing data, because bytes are held back by two positions and the CRC bytes stay inside the block.

Top module: `rx_framer`

## Requirements
- R1: Each byte arrives as 8 data bits, least significant first, followed by one parity bit. Payload bytes leave on `out_data` in arrival order, with `out_valid`/`out_ready` handshaking.
- R2: `sof` starts a new frame. `rx_started` is high in the cycle after `sof` is sampled. A `sof` during a frame abandons it without a done strobe, and keeps only the bytes already released to the output.
- R3: Outside a frame, `bit_valid` and `eof` are ignored. They produce no output byte and no done strobe.
- R4: Parity is odd: the 8 data bits plus the parity bit must hold an odd number of ones. Any failing byte sets `err_parity` at frame end, and that byte is still forwarded.
- R5: The CRC uses polynomial x^16+x^12+x^5+1 in bit-reversed form (0x8408), shifts right, starts at 0xFFFF, and runs over every received byte. The check value is appended low byte first. A non-zero final register sets `err_crc`, and the last two bytes of a frame are never output.
- R6: An `eof` while 1 to 8 bits of a byte are pending sets `err_frame`.
- R7: A frame with fewer than two complete bytes sets `err_frame`, leaves `err_crc` low and outputs nothing.
- R8: `frame_done` is a one-cycle pulse two cycles after `eof` is sampled. The error flags are only ever high together with `frame_done`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds.
- R10: A payload byte that arrives while the output queue (`FIFO_DEPTH` entries plus the output register) is full is dropped, and that frame reports `err_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe qualifying `bit_data` |
| bit_data | input | 1 | Recovered serial bit |
| sof | input | 1 | Start-of-frame marker pulse |
| eof | input | 1 | End-of-frame marker pulse |
| out_valid | output | 1 | Payload byte available |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Consumer accepts the byte |
| rx_started | output | 1 | Pulse after a frame start |
| frame_done | output | 1 | Pulse at frame end |
| err_parity | output | 1 | A byte had bad parity |
| err_crc | output | 1 | CRC residue non-zero |
| err_frame | output | 1 | Partial byte, short frame or overflow |

## Verification
The assertions check on every cycle:
- the output port holds steady under backpressure;
- `rx_started` follows `sof` by one cycle;
- `frame_done` is a single-cycle pulse that comes exactly two cycles after `eof`;
- no error flag is raised outside a done pulse.

Only the bench scenarios can show the rest. These are:
- byte assembly order;
- removal of parity and CRC bytes;
- the CRC residue decision;
- classification of partial, short, aborted and overflowing frames;
- the silence outside frames.

The bench covers these with directed frames and seeded random traffic.

// File: rtl/rx_framer_pkg.sv
package rx_framer_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_INIT     = 16'hFFFF;

  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [7:0]       d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REV;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rx_bit_packer.sv
module rx_bit_packer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          bit_en,
  input  logic          bit_in,
  input  logic          end_en,
  output logic          byte_vld,
  output logic [DW-1:0] byte_data,
  output logic          byte_perr,
  output logic          end_vld,
  output logic          end_partial
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic          completes;
  logic [CW-1:0] cnt_after;

  assign completes = bit_en && (cnt == LAST);

  always_comb begin
    if (completes)   cnt_after = '0;
    else if (bit_en) cnt_after = cnt + 1'b1;
    else             cnt_after = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt         <= '0;
      shreg       <= '0;
      byte_vld    <= 1'b0;
      byte_data   <= '0;
      byte_perr   <= 1'b0;
      end_vld     <= 1'b0;
      end_partial <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      end_vld  <= 1'b0;
      if (completes) begin
        byte_vld  <= 1'b1;
        byte_data <= shreg;
        byte_perr <= ~(^shreg ^ bit_in);
      end else if (bit_en) begin
        shreg <= {bit_in, shreg[DW-1:1]};
      end
      if (end_en) begin
        end_vld     <= 1'b1;
        end_partial <= (cnt_after != '0);
        cnt         <= '0;
      end else begin
        cnt <= cnt_after;
      end
    end
  end
endmodule

// File: rtl/rx_crc_unit.sv
module rx_crc_unit
  import rx_framer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             upd,
  input  logic [DW-1:0]    data,
  output logic [CRC_W-1:0] crc_nx
);
  logic [CRC_W-1:0] crc_q;

  assign crc_nx = upd ? crc_step_byte(crc_q, data) : crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= CRC_INIT;
    else              crc_q <= crc_nx;
  end
endmodule

// File: rtl/rx_out_fifo.sv
module rx_out_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] count;
  logic          wr, ld;

  assign full = (count == NW'(DEPTH));
  assign wr   = push && !full;
  assign ld   = (!out_valid || out_ready) && (count != '0);

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      count     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (ld) begin
        out_data  <= mem[rp];
        out_valid <= 1'b1;
        rp        <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      count <= count + NW'(wr) - NW'(ld);
    end
  end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_framer_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_valid,
  input  logic          bit_data,
  input  logic          sof,
  input  logic          eof,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          rx_started,
  output logic          frame_done,
  output logic          err_parity,
  output logic          err_crc,
  output logic          err_frame
);
  localparam int HOLD = 2;
  localparam int HW   = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HFULL = HW'(HOLD);

  logic             in_frame;
  logic             take_bit, take_eof;
  logic             byte_vld, byte_perr, end_vld, end_partial;
  logic [DW-1:0]    byte_data;
  logic [CRC_W-1:0] crc_nx;
  logic [DW-1:0]    hold [HOLD];
  logic [HW-1:0]    hcnt, hcnt_nx;
  logic             par_st, par_nx, ovf_st, ovf_nx;
  logic             byte_go, push, fifo_full;

  assign take_bit = in_frame && bit_valid && !sof;
  assign take_eof = in_frame && eof && !sof;

  rx_bit_packer #(.DW(DW)) u_pack (
    .clk(clk), .rst(rst), .clear(sof),
    .bit_en(take_bit), .bit_in(bit_data), .end_en(take_eof),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_perr(byte_perr),
    .end_vld(end_vld), .end_partial(end_partial)
  );

  assign byte_go = byte_vld && !sof;
  assign push    = byte_go && (hcnt == HFULL);
  assign hcnt_nx = (byte_go && hcnt != HFULL) ? hcnt + 1'b1 : hcnt;
  assign par_nx  = par_st | (byte_go & byte_perr);
  assign ovf_nx  = ovf_st | (push & fifo_full);

  rx_crc_unit #(.DW(DW)) u_crc (
    .clk(clk), .rst(rst), .clear(sof),
    .upd(byte_go), .data(byte_data), .crc_nx(crc_nx)
  );

  rx_out_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_data(hold[HOLD-1]), .full(fifo_full),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      hcnt       <= '0;
      par_st     <= 1'b0;
      ovf_st     <= 1'b0;
      rx_started <= 1'b0;
      frame_done <= 1'b0;
      err_parity <= 1'b0;
      err_crc    <= 1'b0;
      err_frame  <= 1'b0;
    end else begin
      rx_started <= sof;
      frame_done <= 1'b0;
      err_parity <= 1'b0;
      err_crc    <= 1'b0;
      err_frame  <= 1'b0;
      if (end_vld) begin
        frame_done <= 1'b1;
        err_parity <= par_nx;
        err_crc    <= (hcnt_nx == HFULL) && (crc_nx != '0);
        err_frame  <= end_partial || (hcnt_nx != HFULL) || ovf_nx;
      end
      if (sof) begin
        in_frame <= 1'b1;
        hcnt     <= '0;
        par_st   <= 1'b0;
        ovf_st   <= 1'b0;
      end else begin
        if (take_eof) in_frame <= 1'b0;
        hcnt   <= hcnt_nx;
        par_st <= par_nx;
        ovf_st <= ovf_nx;
      end
    end
  end

  generate
    for (genvar g = 0; g < HOLD; g++) begin : g_hold
      always_ff @(posedge clk) begin
        if (rst)          hold[g] <= '0;
        else if (byte_go) hold[g] <= (g == 0) ? byte_data : hold[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate
endmodule

// File: rtl/rx_framer_chk.sv
module rx_framer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sof,
  input logic          eof,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          out_ready,
  input logic          rx_started,
  input logic          frame_done,
  input logic          err_parity,
  input logic          err_crc,
  input logic          err_frame
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  start_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sof |=> rx_started);

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_started |-> $past(sof));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R8
  done_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(eof, 2));

  // R8
  flags_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (err_parity || err_crc || err_frame) |-> frame_done);
endmodule

bind rx_framer rx_framer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sof(sof), .eof(eof),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .rx_started(rx_started), .frame_done(frame_done),
  .err_parity(err_parity), .err_crc(err_crc), .err_frame(err_frame)
);

// File: tb/rx_framer_bench.sv
module rx_framer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0, bit_data = 1'b0, sof = 1'b0, eof = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, rx_started, frame_done, err_parity, err_crc, err_frame;
  logic [7:0] out_data;

  int n_cmp = 0, n_bad = 0, done_cnt = 0, rdy_mode = 2;
  logic [7:0] got_q[$], exp_q[$], pay_q[$];

  always #2 clk = ~clk;

  rx_framer u_rx_framer (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .sof(sof), .eof(eof), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .rx_started(rx_started), .frame_done(frame_done),
    .err_parity(err_parity), .err_crc(err_crc), .err_frame(err_frame)
  );

  always @(posedge clk) begin
    if (rdy_mode == 0)      out_ready <= ($urandom_range(0, 3) != 0);
    else if (rdy_mode == 1) out_ready <= 1'b0;
    else                    out_ready <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) got_q.push_back(out_data);
      if (frame_done) done_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c = c_in;
    for (int i = 0; i < 8; i++) c = (c[0] ^ d[i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_data = b;
    @(negedge clk); bit_valid = 1'b0;
    repeat ($urandom_range(1, 3)) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit bad_par);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(bad_par ? ^d : ~^d);
  endtask

  task automatic start_frame();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    check(rx_started == 1'b1, "R2 rx_started after sof", rx_started, 1);
  endtask

  // Sends pay_q plus CRC; keep<0 sends all bytes; cap>=0 limits expected output (overflow).
  task automatic run_frame(input int keep, input int extra_bits, input int bad_idx,
                           input bit crc_bad, input int cap);
    logic [7:0] all_q[$];
    logic [15:0] c = 16'hFFFF;
    int n, nexp;
    bit e_frame, e_crc, e_par;
    foreach (pay_q[i]) begin all_q.push_back(pay_q[i]); c = crc_b(c, pay_q[i]); end
    all_q.push_back(c[7:0] ^ (crc_bad ? 8'h01 : 8'h00));
    all_q.push_back(c[15:8]);
    n = (keep < 0) ? all_q.size() : keep;
    start_frame();
    for (int i = 0; i < n; i++) send_byte(all_q[i], i == bad_idx);
    for (int i = 0; i < extra_bits; i++) send_bit($urandom_range(0, 1));
    nexp = (n >= 2) ? n - 2 : 0;
    if (cap >= 0 && nexp > cap) nexp = cap;
    for (int i = 0; i < nexp; i++) exp_q.push_back(all_q[i]);
    e_par   = (bad_idx >= 0 && bad_idx < n);
    e_crc   = (n >= 2) && crc_bad;
    e_frame = (n < 2) || (extra_bits > 0) || (cap >= 0 && n - 2 > cap);
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    check(frame_done == 1'b0, "R8 done not early", frame_done, 0);
    @(negedge clk);
    check(frame_done == 1'b1, "R8 done two cycles after eof", frame_done, 1);
    check(err_parity == e_par,   "R4 parity flag", err_parity, e_par);
    check(err_crc    == e_crc,   "R5 crc flag",    err_crc,    e_crc);
    check(err_frame  == e_frame, "R6/R7/R10 framing flag", err_frame, e_frame);
    @(negedge clk);
    check(frame_done == 1'b0, "R8 done one cycle", frame_done, 0);
  endtask

  task automatic compare_out(input string tag);
    repeat (60) @(negedge clk);
    check(got_q.size() == exp_q.size(), {tag, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {tag, " byte value"}, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int d0;
    void'($urandom(32'd7));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && frame_done == 0 && rx_started == 0, "R8 reset state", out_valid, 0);

    // R1 R5: good frame
    pay_q = '{8'h01, 8'hA5, 8'h3C};
    run_frame(-1, 0, -1, 0, -1); compare_out("R1 good frame");
    // R4: parity error, byte still forwarded
    pay_q = '{8'hFF, 8'h00, 8'h81};
    run_frame(-1, 0, 1, 0, -1); compare_out("R4 parity frame");
    // R5: CRC corrupted
    pay_q = '{8'h12, 8'h34};
    run_frame(-1, 0, -1, 1, -1); compare_out("R5 crc frame");
    // R5: CRC-only frame, nothing emitted
    pay_q.delete();
    run_frame(-1, 0, -1, 0, -1); compare_out("R5 empty payload");
    // R6: partial byte at eof
    pay_q = '{8'h5A, 8'hC3};
    run_frame(-1, 3, -1, 0, -1); compare_out("R6 partial byte");
    // R7: one byte and zero bytes
    pay_q.delete();
    run_frame(1, 0, -1, 0, -1); compare_out("R7 one byte");
    run_frame(0, 0, -1, 0, -1); compare_out("R7 zero bytes");

    // R3: bits and eof outside a frame are ignored
    d0 = done_cnt;
    for (int i = 0; i < 20; i++) send_bit($urandom_range(0, 1));
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    repeat (5) @(negedge clk);
    check(done_cnt == d0, "R3 no done outside frame", done_cnt, d0);
    compare_out("R3 no bytes outside frame");

    // R2: restart mid-frame keeps only released bytes
    d0 = done_cnt;
    start_frame();
    send_byte(8'h11, 0); send_byte(8'h22, 0); send_byte(8'h33, 0); send_byte(8'h44, 0);
    exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    pay_q = '{8'h9E, 8'h07};
    run_frame(-1, 0, -1, 0, -1);
    check(done_cnt == d0 + 1, "R2 aborted frame has no done", done_cnt, d0 + 1);
    compare_out("R2 restart");

    // R10: overflow with consumer stalled (8 queue + 1 output register)
    rdy_mode = 1;
    pay_q.delete();
    for (int i = 0; i < 12; i++) pay_q.push_back(8'(8'h40 + i));
    run_frame(-1, 0, -1, 0, 9);
    check(out_valid == 1'b1, "R9 valid held while stalled", out_valid, 1);
    rdy_mode = 2;
    compare_out("R10 overflow");

    // Random frames, R1 R4 R5 R7 under backpressure
    rdy_mode = 0;
    for (int f = 0; f < 30; f++) begin
      int len = $urandom_range(0, 10);
      pay_q.delete();
      for (int i = 0; i < len; i++) pay_q.push_back(8'($urandom_range(0, 255)));
      run_frame(-1, ($urandom_range(0, 9) == 0) ? $urandom_range(1, 8) : 0,
                ($urandom_range(0, 9) == 0) ? $urandom_range(0, len + 1) : -1,
                ($urandom_range(0, 6) == 0), -1);
      compare_out("R1 random frame");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule